// File: doc/BRIEF.md
# SDRAM Initialization Command Translator

This block sits between a host request channel and the command/address lines of an SDRAM. A 16-bit control word holds a 3-bit mode field. While that field is in normal mode, each host request goes straight through to the regular access path on `pass_req`, and this block stays silent. In any of the four special modes, the block does not run a read or write. Firmware uses these modes to bring memory up and to detect it. Each host request becomes one fixed SDRAM command: a no-operation, a precharge of all banks, a mode-register load, or an auto refresh.

For a mode-register load, the block puts a fixed setup word on the memory address lines. The word sets a burst of four, interleaved ordering, and a CAS-latency bit taken from the `cas_lat_sel` input.

The block remembers whether a no-operation has been sent since reset. A special command asked for before that point goes out as a no-operation instead, and a sticky error flag is set. A reserved mode value behaves exactly like normal mode and sets its own sticky flag.

Top module: `sdram_initcmd_xlate`

## Requirements
- R1: After reset the control word reads 0000h, `cmd_valid` and `host_ack` are low, and both `seq_err` and `rsvd_mode_err` are low.
- R2: A write stores bits 8:6 of `cfg_wdata` as the mode field. Every other bit of `cfg_rdata` reads as zero. The stored field reads back the value as written, reserved values included.
- R3: In normal mode (field 000), `pass_req` equals `host_req` while no command is in flight. No command strobe and no acknowledge are produced.
- R4: In mode 001, a request issues the no-operation code 0111 on `cmd_code` = {CS#, RAS#, CAS#, WE#}, with `cmd_ma` = 000h.
- R5: In mode 010, once a no-operation has been issued, a request issues precharge code 0010 with `cmd_ma` = 400h (bit 10 high, all other bits low).
- R6: In mode 011, once a no-operation has been issued, a request issues mode-register code 0000. `cmd_ma` bits 2:0 are 010, bit 3 is 1, bit 4 equals `cas_lat_sel`, bits 6:5 are 01 and bits 11:7 are zero. This gives 02Ah when `cas_lat_sel` is 0 and 03Ah when it is 1.
- R7: In mode 100, once a no-operation has been issued, a request issues auto-refresh code 0001 with `cmd_ma` = 000h.
- R8: Suppose a special-mode request is first seen high at clock edge k while the block is idle. Then `cmd_valid` is high for exactly the cycle after edge k, and `host_ack` is high for exactly the cycle after edge k+1. Each request held until its acknowledge yields exactly one command.
- R9: Before any no-operation has been issued since reset, a request in mode 010, 011 or 100 issues code 0111 with `cmd_ma` = 000h. It also sets `seq_err`, which stays set until reset. That substituted no-operation counts as the first one.
- R10: Writing a mode field of 101, 110 or 111 sets `rsvd_mode_err`, which stays set until reset. While such a value is stored, requests behave as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word read data |
| cas_lat_sel | input | 1 | CAS-latency bit placed on address bit 4 of a mode-register load |
| host_req | input | 1 | Host DRAM request, held until acknowledged in special modes |
| host_ack | output | 1 | One-cycle acknowledge of a special-mode request |
| pass_req | output | 1 | Request forwarded to the regular access path |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 4 | Command {CS#, RAS#, CAS#, WE#}; 0111 when idle |
| cmd_ma | output | 12 | Memory address word for the command |
| seq_err | output | 1 | Sticky: special command requested before any no-operation |
| rsvd_mode_err | output | 1 | Sticky: reserved mode value written |

## Verification
Some properties are checked by assertions on every cycle. A strobe is always followed by exactly one acknowledge and never by a second strobe. An acknowledge never appears without a preceding strobe. A non-NOP command never appears before a no-operation has been recorded. The mode-register address pattern and the precharge bit 10 hold whenever those codes are strobed. Both error flags, once set, stay set. Forwarding and the strobe never overlap.

Other behaviour only the bench scenarios can show. These are the exact code and address chosen for each mode, the NOP substitution after a fresh reset, reserved modes falling back to forwarding, register readback masking, and the precise acknowledge cycle.

// File: rtl/sdxl_pkg.sv
package sdxl_pkg;
   localparam int MODE_W = 3;
   localparam int CMD_W  = 4;

   localparam logic [MODE_W-1:0] MODE_NORMAL = 3'b000;
   localparam logic [MODE_W-1:0] MODE_NOP    = 3'b001;
   localparam logic [MODE_W-1:0] MODE_PALL   = 3'b010;
   localparam logic [MODE_W-1:0] MODE_MRS    = 3'b011;
   localparam logic [MODE_W-1:0] MODE_CBR    = 3'b100;

   // {CS#, RAS#, CAS#, WE#}
   localparam logic [CMD_W-1:0] CMD_NOP  = 4'b0111;
   localparam logic [CMD_W-1:0] CMD_PALL = 4'b0010;
   localparam logic [CMD_W-1:0] CMD_MRS  = 4'b0000;
   localparam logic [CMD_W-1:0] CMD_CBR  = 4'b0001;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_ACK   = 2'd2
   } sdxl_state_e;

   function automatic logic mode_is_reserved(input logic [MODE_W-1:0] m);
      return m > MODE_CBR;
   endfunction
endpackage

// File: rtl/sdxl_cfg_reg.sv
module sdxl_cfg_reg
   import sdxl_pkg::*;
#(
   parameter int REG_W    = 16,
   parameter int MODE_LSB = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   output logic [MODE_W-1:0] mode_eff,
   output logic              rsvd_flag
);
   localparam int MODE_MSB = MODE_LSB + MODE_W - 1;

   if (MODE_MSB >= REG_W) begin : g_bad_field
      $error("mode field does not fit the control word");
   end

   logic [MODE_W-1:0] mode_q;
   logic              unused_wbits;

   assign unused_wbits = ^{wdata[REG_W-1:MODE_MSB+1], wdata[MODE_LSB-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= MODE_NORMAL;
         rsvd_flag <= 1'b0;
      end else if (wr_en) begin
         mode_q <= wdata[MODE_MSB:MODE_LSB];
         if (mode_is_reserved(wdata[MODE_MSB:MODE_LSB]))
            rsvd_flag <= 1'b1;
      end
   end

   always_comb begin
      rdata                   = '0;
      rdata[MODE_MSB:MODE_LSB] = mode_q;
   end

   assign mode_eff = mode_is_reserved(mode_q) ? MODE_NORMAL : mode_q;

   assert_rsvd_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsvd_flag |=> rsvd_flag);
   assert_rsvd_acts_normal_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mode_is_reserved(rdata[MODE_MSB:MODE_LSB]) |-> mode_eff == MODE_NORMAL);
endmodule

// File: rtl/sdxl_cmd_encode.sv
module sdxl_cmd_encode
   import sdxl_pkg::*;
#(
   parameter int          MA_W        = 12,
   parameter int          AP_BIT      = 10,
   parameter logic [2:0]  BURST_CODE  = 3'b010,
   parameter logic        WRAP_ILV    = 1'b1,
   parameter logic [1:0]  OPMODE_CODE = 2'b01
) (
   input  logic [MODE_W-1:0] mode,
   input  logic              nop_done,
   input  logic              cas_bit,
   output logic [CMD_W-1:0]  code,
   output logic [MA_W-1:0]   ma,
   output logic              force_nop
);
   localparam int MRS_USED = 7;

   if (MA_W <= AP_BIT || MA_W < MRS_USED) begin : g_bad_width
      $error("address width too small for command encoding");
   end

   logic [MA_W-1:0] mrs_word;
   logic [MA_W-1:0] pall_word;

   always_comb begin
      mrs_word      = '0;
      mrs_word[2:0] = BURST_CODE;
      mrs_word[3]   = WRAP_ILV;
      mrs_word[4]   = cas_bit;
      mrs_word[6:5] = OPMODE_CODE;
   end

   always_comb begin
      pall_word         = '0;
      pall_word[AP_BIT] = 1'b1;
   end

   always_comb begin
      force_nop = 1'b0;
      code      = CMD_NOP;
      ma        = '0;
      unique case (mode)
         MODE_PALL: begin code = CMD_PALL; ma = pall_word; end
         MODE_MRS:  begin code = CMD_MRS;  ma = mrs_word;  end
         MODE_CBR:  begin code = CMD_CBR;  ma = '0;        end
         default:   begin code = CMD_NOP;  ma = '0;        end
      endcase
      if (!nop_done && mode != MODE_NOP && mode != MODE_NORMAL) begin
         force_nop = 1'b1;
         code      = CMD_NOP;
         ma        = '0;
      end
   end
endmodule

// File: rtl/sdxl_issue_fsm.sv
module sdxl_issue_fsm
   import sdxl_pkg::*;
#(
   parameter int MA_W     = 12,
   parameter bit PASS_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic [MODE_W-1:0] mode,
   input  logic [CMD_W-1:0]  enc_code,
   input  logic [MA_W-1:0]   enc_ma,
   input  logic              enc_force_nop,
   output logic              nop_done,
   output logic              host_ack,
   output logic              pass_req,
   output logic              cmd_valid,
   output logic [CMD_W-1:0]  cmd_code,
   output logic [MA_W-1:0]   cmd_ma,
   output logic              seq_err
);
   sdxl_state_e      state_q;
   logic [CMD_W-1:0] code_q;
   logic [MA_W-1:0]  ma_q;
   logic             accept;
   logic             pass_raw;

   assign accept   = (state_q == ST_IDLE) && host_req && (mode != MODE_NORMAL);
   assign pass_raw = (state_q == ST_IDLE) && host_req && (mode == MODE_NORMAL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         code_q   <= CMD_NOP;
         ma_q     <= '0;
         nop_done <= 1'b0;
         seq_err  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (accept) begin
               state_q <= ST_ISSUE;
               code_q  <= enc_code;
               ma_q    <= enc_ma;
               if (enc_code == CMD_NOP) nop_done <= 1'b1;
               if (enc_force_nop)       seq_err  <= 1'b1;
            end
            ST_ISSUE: state_q <= ST_ACK;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign cmd_valid = (state_q == ST_ISSUE);
   assign host_ack  = (state_q == ST_ACK);
   assign cmd_code  = cmd_valid ? code_q : CMD_NOP;
   assign cmd_ma    = cmd_valid ? ma_q : '0;

   if (PASS_REG) begin : g_pass_reg
      logic pass_q;
      always_ff @(posedge clk) begin
         if (!rst_n) pass_q <= 1'b0;
         else        pass_q <= pass_raw;
      end
      assign pass_req = pass_q;
   end else begin : g_pass_comb
      assign pass_req = pass_raw;
   end

   assert_strobe_then_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> host_ack && !cmd_valid);
   assert_ack_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      host_ack |-> $past(cmd_valid));
   assert_nop_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code != CMD_NOP) |-> nop_done);
   assert_seq_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |=> seq_err);
   assert_pass_excludes_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pass_raw |-> !cmd_valid && !host_ack);
endmodule

// File: rtl/sdram_initcmd_xlate.sv
module sdram_initcmd_xlate
   import sdxl_pkg::*;
#(
   parameter int REG_W    = 16,
   parameter int MODE_LSB = 6,
   parameter int MA_W     = 12,
   parameter int AP_BIT   = 10,
   parameter bit PASS_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr_en,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   input  logic             cas_lat_sel,
   input  logic             host_req,
   output logic             host_ack,
   output logic             pass_req,
   output logic             cmd_valid,
   output logic [CMD_W-1:0] cmd_code,
   output logic [MA_W-1:0]  cmd_ma,
   output logic             seq_err,
   output logic             rsvd_mode_err
);
   logic [MODE_W-1:0] mode_eff;
   logic [CMD_W-1:0]  enc_code;
   logic [MA_W-1:0]   enc_ma;
   logic              enc_force_nop;
   logic              nop_done;

   sdxl_cfg_reg #(.REG_W(REG_W), .MODE_LSB(MODE_LSB)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr_en),
      .wdata     (cfg_wdata),
      .rdata     (cfg_rdata),
      .mode_eff  (mode_eff),
      .rsvd_flag (rsvd_mode_err)
   );

   sdxl_cmd_encode #(.MA_W(MA_W), .AP_BIT(AP_BIT)) u_enc (
      .mode      (mode_eff),
      .nop_done  (nop_done),
      .cas_bit   (cas_lat_sel),
      .code      (enc_code),
      .ma        (enc_ma),
      .force_nop (enc_force_nop)
   );

   sdxl_issue_fsm #(.MA_W(MA_W), .PASS_REG(PASS_REG)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .host_req      (host_req),
      .mode          (mode_eff),
      .enc_code      (enc_code),
      .enc_ma        (enc_ma),
      .enc_force_nop (enc_force_nop),
      .nop_done      (nop_done),
      .host_ack      (host_ack),
      .pass_req      (pass_req),
      .cmd_valid     (cmd_valid),
      .cmd_code      (cmd_code),
      .cmd_ma        (cmd_ma),
      .seq_err       (seq_err)
   );

   assert_mrs_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == CMD_MRS) |->
         (cmd_ma[2:0] == 3'b010 && cmd_ma[3] && cmd_ma[6:5] == 2'b01
          && cmd_ma[MA_W-1:7] == '0));
   assert_pall_ap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == CMD_PALL) |-> cmd_ma[AP_BIT]);
endmodule

// File: tb/sdram_initcmd_xlate_bench.sv
`timescale 1ns/1ps
module sdram_initcmd_xlate_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        cas_lat_sel = 1'b0;
   logic        host_req = 1'b0;
   logic        host_ack, pass_req, cmd_valid, seq_err, rsvd_mode_err;
   logic [3:0]  cmd_code;
   logic [11:0] cmd_ma;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   logic [15:0] exp_q[$];

   always #4 clk = ~clk;

   sdram_initcmd_xlate u_sdram_initcmd_xlate (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .cas_lat_sel(cas_lat_sel), .host_req(host_req),
      .host_ack(host_ack), .pass_req(pass_req), .cmd_valid(cmd_valid),
      .cmd_code(cmd_code), .cmd_ma(cmd_ma), .seq_err(seq_err),
      .rsvd_mode_err(rsvd_mode_err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   // monitor: every strobe must match the oldest expected command
   always @(negedge clk) begin
      if (rst_n && cmd_valid) begin
         if (exp_q.size() == 0) begin
            check("R8 unexpected strobe", 32'(cmd_code), 32'hF);
         end else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            check("R4-7/R9 code", 32'(cmd_code), 32'(e[15:12]));
            check("R4-7/R9 ma", 32'(cmd_ma), 32'(e[11:0]));
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic cfg_write(input logic [15:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1;
      cfg_wdata = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   // driver: special-mode request, expectation pushed to scoreboard
   task automatic special_req(input string req, input logic [3:0] code, input logic [11:0] ma);
      exp_q.push_back({code, ma});
      @(negedge clk);
      host_req = 1'b1;
      @(negedge clk);
      check({req, " R8 strobe cycle"}, 32'(cmd_valid), 1);
      check({req, " R8 no early ack"}, 32'(host_ack), 0);
      @(negedge clk);
      check({req, " R8 ack cycle"}, 32'(host_ack), 1);
      check({req, " R8 strobe single"}, 32'(cmd_valid), 0);
      host_req = 1'b0;
      @(negedge clk);
      check({req, " R8 quiet after ack"}, 32'(cmd_valid | host_ack), 0);
   endtask

   task automatic normal_req(input string req);
      @(negedge clk);
      host_req = 1'b1;
      #1;
      check({req, " pass_req"}, 32'(pass_req), 1);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check({req, " no strobe/ack"}, 32'(cmd_valid | host_ack), 0);
      end
      host_req = 1'b0;
      #1;
      check({req, " pass_req drops"}, 32'(pass_req), 0);
   endtask

   initial begin
      #(8 * 20000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      do_reset();
      @(negedge clk);
      check("R1 rdata", 32'(cfg_rdata), 0);
      check("R1 strobe/ack", 32'(cmd_valid | host_ack), 0);
      check("R1 flags", 32'({seq_err, rsvd_mode_err}), 0);
      check("R1 idle code", 32'(cmd_code), 32'h7);

      normal_req("R3 normal");

      // R2: junk in reserved bits, mode 010
      cfg_write(16'hFE80);
      check("R2 readback mask", 32'(cfg_rdata), 32'h0080);

      // R9: precharge before any NOP becomes NOP
      special_req("R9 early pall", 4'b0111, 12'h000);
      check("R9 seq_err set", 32'(seq_err), 1);
      // R5: now a real precharge
      special_req("R5 pall", 4'b0010, 12'h400);

      cfg_write(16'h0040);
      special_req("R4 nop", 4'b0111, 12'h000);

      cfg_write(16'h00C0);
      cas_lat_sel = 1'b0;
      special_req("R6 mrs cas0", 4'b0000, 12'h02A);
      cas_lat_sel = 1'b1;
      special_req("R6 mrs cas1", 4'b0000, 12'h03A);

      cfg_write(16'h0100);
      special_req("R7 cbr", 4'b0001, 12'h000);
      check("R9 seq_err sticky", 32'(seq_err), 1);

      // R10: reserved modes act as normal
      check("R10 flag clear before", 32'(rsvd_mode_err), 0);
      cfg_write(16'h0140);
      check("R10 flag set", 32'(rsvd_mode_err), 1);
      check("R2 reserved readback", 32'(cfg_rdata), 32'h0140);
      normal_req("R10 mode101");
      cfg_write(16'h01C0);
      normal_req("R10 mode111");
      cfg_write(16'h0000);
      check("R10 flag sticky", 32'(rsvd_mode_err), 1);
      normal_req("R3 normal again");

      // fresh reset: NOP tracking restarts
      do_reset();
      @(negedge clk);
      check("R1 flags after reset", 32'({seq_err, rsvd_mode_err}), 0);
      check("R1 rdata after reset", 32'(cfg_rdata), 0);
      cfg_write(16'h0100);
      special_req("R9 early cbr", 4'b0111, 12'h000);
      check("R9 seq_err again", 32'(seq_err), 1);
      special_req("R7 cbr after nop", 4'b0001, 12'h000);

      cfg_write(16'h00C0);
      cas_lat_sel = 1'b0;
      special_req("R6 mrs after reset", 4'b0000, 12'h02A);

      repeat (2) @(negedge clk);
      check("R8 scoreboard drained", 32'(exp_q.size()), 0);
      done = 1'b1;
      finish_run();
   end
endmodule